// File: doc/BRIEF.md
# Three-Channel Match-Compare Timer

This peripheral holds three independent up-counters. Each counter has three match comparators. When a comparator matches, it sets a sticky pending bit. A per-comparator enable decides whether that pending bit drives the shared interrupt line. Software reaches every setting through a plain register port that completes in one cycle.

Writes take effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The port moves no stream data, so it has no valid/ready handshake and never applies back-pressure.

The live count is never read directly. Software first writes the capture register of a timer, which freezes the count into a snapshot. A later read of that register returns the snapshot.

Each timer runs in one of two counting modes:
- **Periodic:** the counter restarts at zero after reaching the comparator-0 value.
- **Free-running:** the counter rolls over at its full width.

Address map (byte-free word addresses, 8-bit `bus_addr`):
- `0x00` run-enable register: bit t runs timer t.
- `0x01` mode register: bit t set means timer t is free-running.
- Timer t occupies `(t+1)*8 + off`, with these offsets:
  - `off 0`: reload control, bit 0.
  - `off 1`: pending status on read, write-1-to-clear on write.
  - `off 2`: interrupt enable, bit k for comparator k.
  - `off 3`: capture.
  - `off 4..6`: match values for comparators 0..2.

Top module: `mt_timer_top`

## Requirements
- R1: Writing the run-enable register so that bit t goes from 0 to 1 restarts timer t at count 0 on that edge. Writing 1 to a bit that is already 1 does not restart the timer. A timer whose bit is 0 holds its count.
- R2: While enabled, a counter increases by exactly one per clock.
- R3: A write to a timer's capture register (offset 3) stores the count that held just before that edge. Reads of offset 3 return this stored value until the next capture write.
- R4: If match 0 holds N-1 and the timer is started, pending bit 0 reads as 0 after N-1 clocks and as 1 after N clocks. The test uses N=16.
- R5: A timer is periodic when its mode bit is 0 and its reload bit is 1. In that case the count goes 0..M0 and then back to 0, giving a period of M0+1 clocks.
- R6: In every other mode combination the counter is free-running. It ignores match 0 for wrapping and rolls over from all-ones to 0. The mode bit set to 1 makes the timer free-running even when the reload bit is 1.
- R7: Comparator k sets pending bit k (offset 1, bit k) on the clock where the running count equals match k. The bit stays set until it is cleared.
- R8: Writing offset 1 clears each pending bit whose data bit is 1. Data bits of 0 leave their pending bits unchanged. A clear wins over a match set in the same cycle.
- R9: `irq` is high exactly when some pending bit of some timer has its enable bit (offset 2, bit k) set.
- R10: A timer's counting, status and capture are unaffected by the activity of the other timers.
- R11: After reset, all registers, counts and snapshots are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters tick on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register word address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined masked match interrupt |

## Verification
The bench builds the timer with 8-bit counters, so rollover can be reached quickly. It restarts a timer for every wait length from 0 to 279 clocks and checks each snapshot against the wait length modulo 256. This separates a correct restart-and-count from an off-by-one start or a broken wrap.

The same sweep runs in periodic mode, with the expected value taken modulo M0+1. A further case sets the mode override and must give the unwrapped count, which tells the two mode controls apart.

Pending bits of three comparators with distinct match values are read on every clock of a window. This pins each setting edge exactly. A clear landed on the matching edge checks the clear-versus-set priority.

Re-enabling a running timer, holding a stopped timer, and masking combinations on `irq` cover the remaining control paths.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_RELOAD  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STATUS  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_IE      = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CAPTURE = 3'd3;
  localparam int               OFF_MATCH0  = 4;
  localparam logic [OFF_W-1:0] OFF_GLB_RUN  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_GLB_MODE = 3'd1;
endpackage

// File: rtl/mt_match_slot.sv
module mt_match_slot #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             wr_match,
  input  logic             wr_ie,
  input  logic             wr_clr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             ie_din,
  input  logic             clr_bit,
  output logic [CNT_W-1:0] match_q,
  output logic             ie_q,
  output logic             status_q,
  output logic             hit
);
  logic clear_now;

  assign hit       = tick && (count == match_q);
  assign clear_now = wr_clr && clr_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q  <= '0;
      ie_q     <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (wr_match) match_q <= wdata;
      if (wr_ie)    ie_q    <= ie_din;
      if (clear_now)  status_q <= 1'b0;
      else if (hit)   status_q <= 1'b1;
    end
  end

  // R8: a clear beats a simultaneous match
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_now |=> !status_q);

  // R7: pending bit is sticky until cleared
  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clear_now) |=> status_q);

  // R7: a match without clear leaves the bit set
  assert_match_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == match_q && !clear_now) |=> status_q);
endmodule

// File: rtl/mt_channel.sv
module mt_channel
  import mt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_MATCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              freerun,
  input  logic              wr_sel,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [CNT_W-1:0]     count_q;
  logic [CNT_W-1:0]     snap_q;
  logic                 reload_q;
  logic [CNT_W-1:0]     match_v [NUM_MATCH];
  logic [NUM_MATCH-1:0] ie_v;
  logic [NUM_MATCH-1:0] st_v;
  logic [NUM_MATCH-1:0] hit_v;
  logic [NUM_MATCH-1:0] wr_match;
  logic                 tick, periodic, wrap;
  logic                 wr_reload, wr_clr, wr_ie, wr_cap;

  assign tick      = run && !start;
  assign periodic  = !freerun && reload_q;
  assign wrap      = periodic && hit_v[0];
  assign wr_reload = wr_sel && (off == OFF_RELOAD);
  assign wr_clr    = wr_sel && (off == OFF_STATUS);
  assign wr_ie     = wr_sel && (off == OFF_IE);
  assign wr_cap    = wr_sel && (off == OFF_CAPTURE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      snap_q   <= '0;
      reload_q <= 1'b0;
    end else begin
      if (start)     count_q <= '0;
      else if (tick) count_q <= wrap ? '0 : count_q + CNT_W'(1);
      if (wr_cap)    snap_q   <= count_q;
      if (wr_reload) reload_q <= wdata[0];
    end
  end

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_slot
    assign wr_match[k] = wr_sel && (off == OFF_W'(OFF_MATCH0 + k));
    mt_match_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .count    (count_q),
      .wr_match (wr_match[k]),
      .wr_ie    (wr_ie),
      .wr_clr   (wr_clr),
      .wdata    (wdata[CNT_W-1:0]),
      .ie_din   (wdata[k]),
      .clr_bit  (wdata[k]),
      .match_q  (match_v[k]),
      .ie_q     (ie_v[k]),
      .status_q (st_v[k]),
      .hit      (hit_v[k])
    );
  end

  assign irq = |(st_v & ie_v);

  always_comb begin
    rdata = '0;
    case (off)
      OFF_RELOAD:  rdata[0]              = reload_q;
      OFF_STATUS:  rdata[NUM_MATCH-1:0]  = st_v;
      OFF_IE:      rdata[NUM_MATCH-1:0]  = ie_v;
      OFF_CAPTURE: rdata[CNT_W-1:0]      = snap_q;
      default: begin
        for (int k = 0; k < NUM_MATCH; k++)
          if (off == OFF_W'(OFF_MATCH0 + k)) rdata[CNT_W-1:0] = match_v[k];
      end
    endcase
  end

  // R1: a start puts the counter at zero
  assert_restart_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count_q == '0);

  // R1: a stopped timer holds its count
  assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(count_q));

  // R2: free-running step of one per clock
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !periodic) |=> count_q == $past(count_q) + CNT_W'(1));

  // R3: snapshot equals the count before the capture edge
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cap |=> snap_q == $past(count_q));
endmodule

// File: rtl/mt_timer_top.sv
module mt_timer_top
  import mt_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_MATCH  = 3,
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int REG_W = ADDR_W - OFF_W;

  logic [REG_W-1:0]      region;
  logic [OFF_W-1:0]      off;
  logic [NUM_TIMERS-1:0] en_q, mode_q, start, ch_irq, ch_wr;
  logic [DATA_W-1:0]     ch_rdata [NUM_TIMERS];
  logic                  wr_run, wr_mode;

  assign region  = bus_addr[ADDR_W-1:OFF_W];
  assign off     = bus_addr[OFF_W-1:0];
  assign wr_run  = bus_wr && (region == '0) && (off == OFF_GLB_RUN);
  assign wr_mode = bus_wr && (region == '0) && (off == OFF_GLB_MODE);
  assign start   = wr_run ? (bus_wdata[NUM_TIMERS-1:0] & ~en_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      if (wr_run)  en_q   <= bus_wdata[NUM_TIMERS-1:0];
      if (wr_mode) mode_q <= bus_wdata[NUM_TIMERS-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    assign ch_wr[t] = bus_wr && (region == REG_W'(t + 1));
    mt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q[t]),
      .start   (start[t]),
      .freerun (mode_q[t]),
      .wr_sel  (ch_wr[t]),
      .off     (off),
      .wdata   (bus_wdata),
      .rdata   (ch_rdata[t]),
      .irq     (ch_irq[t])
    );
  end

  assign irq = |ch_irq;

  always_comb begin
    bus_rdata = '0;
    if (region == '0) begin
      if (off == OFF_GLB_RUN)  bus_rdata = DATA_W'(en_q);
      if (off == OFF_GLB_MODE) bus_rdata = DATA_W'(mode_q);
    end
    for (int t = 0; t < NUM_TIMERS; t++)
      if (region == REG_W'(t + 1)) bus_rdata = ch_rdata[t];
  end

  // R1: a start only happens from a stopped timer
  assert_start_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start != '0) |-> ((start & en_q) == '0));

  // R1: a started timer is running on the next cycle
  assert_start_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start != '0) |=> ((en_q & $past(start)) == $past(start)));
endmodule

// File: tb/mt_timer_top_test.sv
module mt_timer_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [2:0] en_sh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mt_timer_top #(.NUM_TIMERS(3), .NUM_MATCH(3), .CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [AW-1:0] ta(input int t, input int o);
    return AW'((t + 1) * 8 + o);
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic set_en(input logic [2:0] v);
    wr(AW'(0), DW'(v));
    en_sh = v;
  endtask

  task automatic restart(input int t);
    set_en(en_sh & ~(3'b1 << t));
    set_en(en_sh | (3'b1 << t));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irq", irq, 0);
    rd(AW'(0), v);             check("R11 enable", v, 0);
    rd(ta(0, 3), v);           check("R11 snapshot", v, 0);
    rd(ta(1, 1), v);           check("R11 status", v, 0);
    rd(ta(2, 4), v);           check("R11 match", v, 0);

    // R4 match-0 distance N=16, free-running
    wr(ta(0, 4), 32'd15);
    wr(ta(0, 1), 32'h7);
    set_en(3'b001);
    idle(15);
    rd(ta(0, 1), v); check("R4 before N", v[0], 0);
    idle(1);
    rd(ta(0, 1), v); check("R4 at N", v[0], 1);
    check("R9 masked irq", irq, 0);
    wr(ta(0, 2), 32'h1);
    check("R9 enabled irq", irq, 1);
    wr(ta(0, 2), 32'h0);
    check("R9 remasked irq", irq, 0);
    wr(ta(0, 1), 32'h0);
    rd(ta(0, 1), v); check("R8 zero write keeps", v[0], 1);
    wr(ta(0, 1), 32'h1);
    rd(ta(0, 1), v); check("R8 write one clears", v[0], 0);

    // R2 R6 free-running sweep through rollover
    for (int k = 0; k < 280; k++) begin
      restart(0);
      idle(k);
      wr(ta(0, 3), 32'h0);
      rd(ta(0, 3), v);
      check("R2 R6 free count", v, k % 256);
    end

    // R5 periodic sweep with M0=5
    wr(ta(0, 4), 32'd5);
    wr(ta(0, 0), 32'd1);
    for (int k = 0; k < 21; k++) begin
      restart(0);
      idle(k);
      wr(ta(0, 3), 32'h0);
      rd(ta(0, 3), v);
      check("R5 periodic count", v, k % 6);
    end
    // R6 mode bit overrides reload
    wr(AW'(1), 32'h1);
    restart(0);
    idle(10);
    wr(ta(0, 3), 32'h0);
    rd(ta(0, 3), v); check("R6 mode override", v, 10);
    wr(AW'(1), 32'h0);
    wr(ta(0, 0), 32'd0);

    // R1 re-enable without restart, then hold
    restart(0);
    idle(3);
    set_en(en_sh);
    wr(ta(0, 3), 32'h0);
    rd(ta(0, 3), v); check("R1 no restart", v, 4);
    set_en(en_sh & 3'b110);
    wr(ta(0, 3), 32'h0);
    rd(ta(0, 3), v); check("R1 stop", v, 6);
    idle(5);
    wr(ta(0, 3), 32'h0);
    rd(ta(0, 3), v); check("R1 hold", v, 6);
    set_en(en_sh | 3'b001);
    idle(10);
    rd(ta(0, 3), v); check("R3 snapshot kept", v, 6);
    set_en(en_sh & 3'b110);

    // R8 clear on the matching edge, timer 1, N=10
    wr(ta(1, 4), 32'd9);
    wr(ta(1, 1), 32'h7);
    set_en(en_sh | 3'b010);
    idle(9);
    wr(ta(1, 1), 32'h1);
    rd(ta(1, 1), v); check("R8 clear wins", v[0], 0);
    idle(1);
    rd(ta(1, 1), v); check("R8 stays clear", v[0], 0);
    restart(1);
    idle(10);
    rd(ta(1, 1), v); check("R7 later match sets", v[0], 1);
    set_en(en_sh & 3'b101);
    wr(ta(1, 1), 32'h7);

    // R7 three comparators on timer 2
    wr(ta(2, 4), 32'd10);
    wr(ta(2, 5), 32'd3);
    wr(ta(2, 6), 32'd7);
    wr(ta(2, 1), 32'h7);
    set_en(en_sh | 3'b100);
    for (int j = 0; j <= 12; j++) begin
      int e;
      e = ((j >= 11) ? 1 : 0) | ((j >= 4) ? 2 : 0) | ((j >= 8) ? 4 : 0);
      rd(ta(2, 1), v);
      check("R7 status bits", v[2:0], e);
      @(negedge clk);
    end

    // R9 mask combinations
    check("R9 all masked", irq, 0);
    wr(ta(2, 2), 32'h4);
    check("R9 one enabled", irq, 1);
    wr(ta(2, 1), 32'h4);
    check("R9 enabled bit cleared", irq, 0);
    rd(ta(2, 1), v); check("R8 selective clear", v[2:0], 3);
    wr(ta(2, 2), 32'h0);

    // R10 timer 0 stopped while timer 2 runs
    wr(ta(0, 3), 32'h0);
    rd(ta(0, 3), v);
    wr(ta(2, 3), 32'h0);
    rd(ta(2, 3), v2);
    idle(5);
    wr(ta(0, 3), 32'h0);
    rd(ta(0, 3), v2);
    check("R10 stopped timer unchanged", v2, v);
    rd(ta(1, 1), v); check("R10 other status untouched", v[2:0], 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule